// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks and peripheral enables stay on in a small controller that has two software-entered low-power modes. The CPU issues a single-cycle strobe to request a light sleep (the processor halts, the bus keeps running) or a deep sleep (the processor halts and the bus clock may halt too). The controller tracks the mode, drives the gating enables for the CPU clock, the bus clock, a voltage monitor, a timebase, a debug/break unit and an ADC sequencer, and brings the system back to running when an allowed wake-up source fires.

The ADC gets special handling. Entering deep sleep sends a one-cycle abort to any conversion that is in progress, and the converter is kept disabled for the whole deep sleep. After an external interrupt ends deep sleep, a settling flag stays high for one conversion period so that downstream logic can discard the first result. A registered wake-source code reports which source ended the last sleep.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is held and right after it, mode is RUN (code 0), both the CPU and bus clock enables are 1, the ADC enable is 1, abort and settling are 0, and the wake-source code is 0.
- R2: A wait strobe in RUN with no stop strobe gives mode WAIT (code 1) on the next cycle, with the CPU clock enable 0 and the bus clock enable 1.
- R3: A stop strobe in RUN gives mode STOP (code 2) on the next cycle, even when a wait strobe arrives in the same cycle. In STOP the CPU clock enable is 0 and the bus clock enable equals the keep-oscillator configuration input.
- R4: In WAIT the voltage-monitor enable is the inverse of its wait-off configuration bit and the timebase enable is the inverse of its own wait-off bit; the two act independently. In RUN both enables are 1.
- R5: In WAIT, any enabled peripheral interrupt, the ADC interrupt or the external interrupt returns the mode to RUN on the next cycle with the CPU clock enable 1. The wake-source code becomes 3 for external, 2 for ADC or 1 for a peripheral interrupt, and the external interrupt has the highest priority and the peripheral interrupt the lowest.
- R6: In STOP, only the external interrupt ends the mode. Peripheral and ADC interrupts leave the mode in STOP.
- R7: Wait and stop strobes that arrive while the mode is WAIT or STOP have no effect.
- R8: Entering STOP while the ADC busy input is 1 raises the abort output during the first STOP cycle only. The ADC enable is 0 for the whole of STOP and 1 in every other mode.
- R9: Leaving STOP through the external interrupt raises the settling output for exactly ADC_CONV_CYCLES cycles, starting with the first RUN cycle. Leaving WAIT never raises it.
- R10: The break-unit clock enable follows the break-enable input in RUN and WAIT and is 0 in STOP.
- R11: In STOP the voltage-monitor enable stays 1, and the timebase enable is 1 only when the keep-oscillator input is 1.
- R12: Asserting reset while in WAIT or STOP puts the mode back to RUN at once and clears the wake-source code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | Single-cycle light-sleep request from the CPU |
| stop_req | input | 1 | Single-cycle deep-sleep request from the CPU |
| cfg_osc_keep | input | 1 | 1 keeps the bus clock and timebase alive in STOP |
| cfg_lvm_off_wait | input | 1 | 1 turns the voltage monitor off in WAIT |
| cfg_tb_off_wait | input | 1 | 1 turns the timebase off in WAIT |
| brk_en | input | 1 | Break/debug unit enabled |
| irq_req | input | N_IRQ | Enabled peripheral interrupt requests |
| adc_irq | input | 1 | Enabled ADC interrupt request |
| ext_irq | input | 1 | External interrupt request |
| adc_busy | input | 1 | ADC conversion in progress |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| bus_clk_en | output | 1 | Bus clock gate enable |
| lvm_en | output | 1 | Voltage-monitor enable |
| tb_en | output | 1 | Timebase enable |
| brk_clk_en | output | 1 | Break-unit clock enable |
| adc_en | output | 1 | ADC sequencer enable |
| adc_abort | output | 1 | One-cycle conversion abort on deep-sleep entry |
| adc_settling | output | 1 | First conversion after deep sleep is not valid |
| wake_src | output | 2 | Cause of the last wake: 0 none, 1 peripheral, 2 ADC, 3 external |
| mode | output | 2 | Current mode: 0 RUN, 1 WAIT, 2 STOP |

## Verification
The bench builds the controller with three peripheral interrupt lines and a settling window of three cycles. Three lines are enough to show that a request on any single line, or on several lines together, wakes from WAIT and is ignored in STOP. The short window lets the walked vector table see the settling flag rise on the first RUN cycle, stay high for the whole window and drop on the exact cycle after it, with no long idle stretch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_WAIT = 2'd1,
        MODE_STOP = 2'd2
    } lpm_mode_e;

    typedef enum logic [1:0] {
        WAKE_NONE = 2'd0,
        WAKE_PERI = 2'd1,
        WAKE_ADC  = 2'd2,
        WAKE_EXT  = 2'd3
    } lpm_wake_e;

endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_req,
    input  logic             stop_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             adc_irq,
    input  logic             ext_irq,
    output lpm_mode_e        mode_o,
    output lpm_wake_e        wake_o,
    output logic             stop_enter_o,
    output logic             stop_exit_o
);

    typedef struct packed {
        lpm_mode_e mode;
        lpm_wake_e wake;
    } fsm_state_t;

    fsm_state_t st_d, st_q;
    logic       any_peri;

    always_comb begin
        any_peri     = |irq_req;
        st_d         = st_q;
        stop_enter_o = 1'b0;
        stop_exit_o  = 1'b0;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (stop_req) begin
                    st_d.mode    = MODE_STOP;
                    stop_enter_o = 1'b1;
                end else if (wait_req) begin
                    st_d.mode = MODE_WAIT;
                end
            end
            MODE_WAIT: begin
                if (ext_irq) begin
                    st_d.mode = MODE_RUN;
                    st_d.wake = WAKE_EXT;
                end else if (adc_irq) begin
                    st_d.mode = MODE_RUN;
                    st_d.wake = WAKE_ADC;
                end else if (any_peri) begin
                    st_d.mode = MODE_RUN;
                    st_d.wake = WAKE_PERI;
                end
            end
            MODE_STOP: begin
                if (ext_irq) begin
                    st_d.mode   = MODE_RUN;
                    st_d.wake   = WAKE_EXT;
                    stop_exit_o = 1'b1;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RUN;
            st_q.wake <= WAKE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign wake_o = st_q.wake;

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN && stop_req) |=> (mode_o == MODE_STOP)); // R3
    AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN && wait_req && !stop_req) |=> (mode_o == MODE_WAIT)); // R2
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_STOP && !ext_irq) |=> (mode_o == MODE_STOP)); // R6
    AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_WAIT && ext_irq) |=> (wake_o == WAKE_EXT && mode_o == MODE_RUN)); // R5
    AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_WAIT && !ext_irq && !adc_irq && !any_peri) |=> (mode_o == MODE_WAIT)); // R7

endmodule

// File: rtl/lpm_adc_guard.sv
module lpm_adc_guard #(
    parameter int ADC_CONV_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_stop,
    input  logic adc_busy,
    input  logic stop_enter,
    input  logic stop_exit,
    output logic abort_o,
    output logic settling_o
);

    localparam int CNT_W = $clog2(ADC_CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ADC_CONV_CYCLES);

    typedef struct packed {
        logic             abort;
        logic [CNT_W-1:0] cnt;
    } guard_state_t;

    guard_state_t g_d, g_q;

    always_comb begin
        g_d       = g_q;
        g_d.abort = stop_enter & adc_busy;
        if (stop_exit) begin
            g_d.cnt = CNT_LOAD;
        end else if (stop_enter) begin
            g_d.cnt = '0;
        end else if (g_q.cnt != '0) begin
            g_d.cnt = g_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.abort <= 1'b0;
            g_q.cnt   <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign abort_o    = g_q.abort;
    assign settling_o = (g_q.cnt != '0);

    AST_ABORT_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> in_stop); // R8
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o); // R8
    AST_SETTLE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        settling_o |-> !in_stop); // R9

endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
    import lpm_pkg::*;
(
    input  lpm_mode_e mode,
    input  logic      cfg_osc_keep,
    input  logic      cfg_lvm_off_wait,
    input  logic      cfg_tb_off_wait,
    input  logic      brk_en,
    output logic      cpu_clk_en,
    output logic      bus_clk_en,
    output logic      lvm_en,
    output logic      tb_en,
    output logic      brk_clk_en,
    output logic      adc_en
);

    localparam int NPER = 2;
    // Per peripheral: index 0 voltage monitor, index 1 timebase.
    // A set bit means the peripheral follows the bus clock in STOP.
    localparam logic [NPER-1:0] STOP_GATED = 2'b10;

    logic            in_wait, in_stop;
    logic [NPER-1:0] wait_off;
    logic [NPER-1:0] per_en;

    assign in_wait  = (mode == MODE_WAIT);
    assign in_stop  = (mode == MODE_STOP);
    assign wait_off = {cfg_tb_off_wait, cfg_lvm_off_wait};

    assign cpu_clk_en = (mode == MODE_RUN);
    assign bus_clk_en = !in_stop || cfg_osc_keep;
    assign brk_clk_en = brk_en && !in_stop;
    assign adc_en     = !in_stop;

    for (genvar i = 0; i < NPER; i++) begin : g_per
        if (STOP_GATED[i]) begin : g_stop_gated
            assign per_en[i] = !(in_wait && wait_off[i]) && !(in_stop && !cfg_osc_keep);
        end else begin : g_stop_kept
            assign per_en[i] = !(in_wait && wait_off[i]);
        end
    end

    assign lvm_en = per_en[0];
    assign tb_en  = per_en[1];

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ           = 4,
    parameter int ADC_CONV_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_req,
    input  logic             stop_req,
    input  logic             cfg_osc_keep,
    input  logic             cfg_lvm_off_wait,
    input  logic             cfg_tb_off_wait,
    input  logic             brk_en,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             adc_irq,
    input  logic             ext_irq,
    input  logic             adc_busy,
    output logic             cpu_clk_en,
    output logic             bus_clk_en,
    output logic             lvm_en,
    output logic             tb_en,
    output logic             brk_clk_en,
    output logic             adc_en,
    output logic             adc_abort,
    output logic             adc_settling,
    output logic [1:0]       wake_src,
    output logic [1:0]       mode
);

    lpm_mode_e mode_w;
    lpm_wake_e wake_w;
    logic      stop_enter, stop_exit;

    lpm_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wait_req     (wait_req),
        .stop_req     (stop_req),
        .irq_req      (irq_req),
        .adc_irq      (adc_irq),
        .ext_irq      (ext_irq),
        .mode_o       (mode_w),
        .wake_o       (wake_w),
        .stop_enter_o (stop_enter),
        .stop_exit_o  (stop_exit)
    );

    lpm_adc_guard #(.ADC_CONV_CYCLES(ADC_CONV_CYCLES)) u_adc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_stop    (mode_w == MODE_STOP),
        .adc_busy   (adc_busy),
        .stop_enter (stop_enter),
        .stop_exit  (stop_exit),
        .abort_o    (adc_abort),
        .settling_o (adc_settling)
    );

    lpm_gate_decode u_gate (
        .mode             (mode_w),
        .cfg_osc_keep     (cfg_osc_keep),
        .cfg_lvm_off_wait (cfg_lvm_off_wait),
        .cfg_tb_off_wait  (cfg_tb_off_wait),
        .brk_en           (brk_en),
        .cpu_clk_en       (cpu_clk_en),
        .bus_clk_en       (bus_clk_en),
        .lvm_en           (lvm_en),
        .tb_en            (tb_en),
        .brk_clk_en       (brk_clk_en),
        .adc_en           (adc_en)
    );

    assign mode     = mode_w;
    assign wake_src = wake_w;

    AST_CPU_OFF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |-> !cpu_clk_en); // R2
    AST_BRK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        brk_clk_en |-> (brk_en && mode != 2'd2)); // R10

endmodule

// File: tb/tb_lpm_clk_ctrl.sv
module tb_lpm_clk_ctrl;

    localparam int NI = 3;
    localparam int NV = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_req = 0, stop_req = 0, cfg_osc_keep = 0, cfg_lvm_off_wait = 0;
    logic cfg_tb_off_wait = 0, brk_en = 0, adc_irq = 0, ext_irq = 0, adc_busy = 0;
    logic [NI-1:0] irq_req = '0;
    logic cpu_clk_en, bus_clk_en, lvm_en, tb_en, brk_clk_en, adc_en;
    logic adc_abort, adc_settling;
    logic [1:0] wake_src, mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lpm_clk_ctrl #(.N_IRQ(NI), .ADC_CONV_CYCLES(3)) dut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
        .cfg_osc_keep(cfg_osc_keep), .cfg_lvm_off_wait(cfg_lvm_off_wait),
        .cfg_tb_off_wait(cfg_tb_off_wait), .brk_en(brk_en), .irq_req(irq_req),
        .adc_irq(adc_irq), .ext_irq(ext_irq), .adc_busy(adc_busy),
        .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .lvm_en(lvm_en),
        .tb_en(tb_en), .brk_clk_en(brk_clk_en), .adc_en(adc_en),
        .adc_abort(adc_abort), .adc_settling(adc_settling),
        .wake_src(wake_src), .mode(mode)
    );

    // Stimulus (MSB..LSB): wait stop irq[2:0] adc_irq ext busy osc lvm_off tb_off brk
    // Expected (MSB..LSB): mode[1:0] cpu bus lvm tb brk_clk adc_en abort settling wake[1:0]
    localparam logic [23:0] VEC [NV] = '{
        {12'b0_0_000_0_0_0_0_0_0_1, 12'b00_1_1_1_1_1_1_0_0_00}, // R4 run
        {12'b1_0_000_0_0_0_0_1_0_1, 12'b01_0_1_0_1_1_1_0_0_00}, // R2 R4 wait, monitor off
        {12'b0_1_000_0_0_0_0_0_1_1, 12'b01_0_1_1_0_1_1_0_0_00}, // R7 R4 stop strobe ignored, timebase off
        {12'b0_0_010_0_0_0_0_0_0_1, 12'b00_1_1_1_1_1_1_0_0_01}, // R5 peripheral wake
        {12'b1_0_000_0_0_0_0_0_0_1, 12'b01_0_1_1_1_1_1_0_0_01}, // R2 wait again
        {12'b0_0_001_1_0_0_0_0_0_1, 12'b00_1_1_1_1_1_1_0_0_10}, // R5 ADC beats peripheral
        {12'b1_1_000_0_0_1_0_0_0_1, 12'b10_0_0_1_0_0_0_1_0_10}, // R3 R8 R11 both strobes, busy
        {12'b0_0_111_1_0_0_1_0_0_1, 12'b10_0_1_1_1_0_0_0_0_10}, // R6 R11 R3 no wake from irqs
        {12'b1_0_000_0_0_0_0_0_0_1, 12'b10_0_0_1_0_0_0_0_0_10}, // R7 R10 wait strobe in stop
        {12'b0_0_000_0_1_0_0_0_0_1, 12'b00_1_1_1_1_1_1_0_1_11}, // R9 external wake, settle 1
        {12'b0_0_000_0_0_0_0_0_0_1, 12'b00_1_1_1_1_1_1_0_1_11}, // R9 settle 2
        {12'b0_0_000_0_0_0_0_0_0_1, 12'b00_1_1_1_1_1_1_0_1_11}, // R9 settle 3
        {12'b0_0_000_0_0_0_0_0_0_1, 12'b00_1_1_1_1_1_1_0_0_11}, // R9 window closed
        {12'b1_0_000_0_0_0_0_0_0_0, 12'b01_0_1_1_1_0_1_0_0_11}, // R10 wait, break off
        {12'b0_0_000_1_1_0_0_0_0_1, 12'b00_1_1_1_1_1_1_0_0_11}, // R5 R9 external first, no settle
        {12'b0_1_000_0_0_0_1_0_0_1, 12'b10_0_1_1_1_0_0_0_0_11}  // R8 R3 stop idle, no abort
    };

    localparam string TAG [NV] = '{
        "R4", "R2", "R7", "R5", "R2", "R5", "R8", "R6",
        "R7", "R9", "R9", "R9", "R9", "R10", "R5", "R3"
    };

    function automatic logic [11:0] obs();
        return {mode, cpu_clk_en, bus_clk_en, lvm_en, tb_en, brk_clk_en,
                adc_en, adc_abort, adc_settling, wake_src};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] s);
        {wait_req, stop_req, irq_req, adc_irq, ext_irq, adc_busy,
         cfg_osc_keep, cfg_lvm_off_wait, cfg_tb_off_wait, brk_en} = s;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", obs(), 12'b00_1_1_1_1_0_1_0_0_00);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk) #1;
        check("R1 after reset", obs(), 12'b00_1_1_1_1_0_1_0_0_00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk) drive(VEC[i][23:12]);
            @(posedge clk) #1;
            check(TAG[i], obs(), VEC[i][11:0]);
        end

        // R12: reset while in STOP
        @(negedge clk) begin drive(12'b0); rst_n = 1'b0; end
        #1 check("R12 reset from stop", {mode, wake_src}, 4'b00_00);
        @(negedge clk) rst_n = 1'b1;
        // R12: reset while in WAIT
        @(negedge clk) drive(12'b1_0_000_0_0_0_0_0_0_0);
        @(posedge clk) #1 check("R2 wait before reset", mode, 2'd1);
        @(negedge clk) begin drive(12'b0); rst_n = 1'b0; end
        #1 check("R12 reset from wait", mode, 2'd0);
        @(negedge clk) rst_n = 1'b1;
        // R9: re-entering stop during the settling window clears it
        @(negedge clk) drive(12'b0_1_000_0_0_0_0_0_0_0);
        @(negedge clk) drive(12'b0_0_000_0_1_0_0_0_0_0);
        @(posedge clk) #1 check("R9 settle after stop", adc_settling, 1'b1);
        @(negedge clk) drive(12'b0_1_000_0_0_1_0_0_0_0);
        @(posedge clk) #1 check("R8 abort on second stop", {mode, adc_abort, adc_settling}, 4'b10_1_0);
        @(negedge clk) drive(12'b0);
        @(posedge clk) #1 check("R8 abort one cycle", {adc_abort, adc_en}, 2'b00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule